// File: doc/BRIEF.md
# Network Controller Command and Interrupt Registers

This block holds the command byte, the interrupt status byte and the interrupt mask of a legacy Ethernet controller's register file, behind an 8-bit register port. A command write is decoded into a page select, a three-bit remote DMA command, a transmit request, a start flag and a stop flag. The status flags are set by one-cycle event pulses from the receive, transmit and DMA engines, and software clears them by writing ones. A single level interrupt output reflects any flag whose mask bit is set.

The block also starts the transmit handshake. A transmit command raises a one-cycle `txStart` pulse and holds `txBusy` until the transmitter reports completion. A sticky reset-status flag records that the controller was stopped. Only a command write that turns start on while start was off clears that flag. Register reads are combinational. Writes take effect at the clock edge on which `regWr` is sampled high.

Top module: `nic_cmd_irq`

## Requirements
- R1: The command byte reads back as {page[7:6], dmaCode[5:3], txBusy[2], start[1], stop[0]}. A command write stores the page, the DMA code and start from bits 7:6, 5:3 and 1. `pageSel`, `dmaCmd`, `running` and `stopped` show the stored values. The command register sits at offset 0 on every page.
- R2: A command write whose bits 5:3 are 0 stores DMA code 4 instead.
- R3: A command write with bit 0 set sets the stop flag and the reset-status flag (status bit 7). A command write with bit 0 clear clears the stop flag.
- R4: The reset-status flag clears only on a command write that sets bit 1 while start was 0. This takes priority over a stop in the same write. Writes to the status register never change it.
- R5: Status bits: 7 reset, 6 remote DMA done (`dmaDoneEv`), 5 counter overflow (`cntOvfEv`), 4 buffer overwrite (`ovwEv`), 3 transmit error (`txErrEv`), 2 receive error (`rxErrEv`), 1 packet transmitted, 0 packet received (`rxDoneEv`). Each event pulse sets its bit at the next edge. Status is read and written at offset 7 of page 0.
- R6: Writing the status register clears each of bits 6:0 that is written as 1 and leaves the others unchanged. Status writes on any page other than 0 are ignored.
- R7: The mask is written at offset 15 of page 0 and enables status bits 6:0 one-for-one. `irq` is high exactly while some status bit 6:0 and its mask bit are both 1. It drops after a clear or a mask write removes the last such pair.
- R8: After reset: command byte 0x21 (stop=1, DMA code 4, page 0), status 0x80, mask 0, `irq` low, `txBusy` and `txOk` low.
- R9: A command write with DMA code 1 and bit 1 set, made while `remCntZero` is high, sets status bit 6 at once. If `remCntZero` is low or bit 1 is clear, status bit 6 is not set.
- R10: A command write with bit 2 set, while not busy, pulses `txStart` for one cycle, sets `txBusy` and clears `txOk`. A `txDoneEv` pulse while busy clears `txBusy`, sets `txOk` and sets status bit 1.
- R11: An event pulse in the same cycle as a status write that clears the same bit leaves the bit set.
- R12: A transmit command while `txBusy` is high produces no `txStart` pulse. A `txDoneEv` pulse while not busy changes neither the status register nor `txOk`.
- R13: The mask reads back at offset 15 of page 2, with bit 7 as 0. Writes there are ignored. Every other offset outside the command and status registers reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 4 | Register offset |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Combinational read data for regAddr |
| rxDoneEv | input | 1 | Packet received pulse |
| rxErrEv | input | 1 | Receive error pulse |
| txErrEv | input | 1 | Transmit error pulse |
| ovwEv | input | 1 | Buffer overwrite pulse |
| cntOvfEv | input | 1 | Tally counter overflow pulse |
| dmaDoneEv | input | 1 | Remote DMA done pulse |
| txDoneEv | input | 1 | Transmit completion pulse |
| remCntZero | input | 1 | Remote byte count is zero |
| irq | output | 1 | Level interrupt |
| txStart | output | 1 | One-cycle transmit start pulse |
| txBusy | output | 1 | Transmit in progress |
| txOk | output | 1 | Last transmit completed |
| pageSel | output | 2 | Stored page select |
| dmaCmd | output | 3 | Stored remote DMA code |
| running | output | 1 | Start flag |
| stopped | output | 1 | Stop flag |

## Verification
The hardest state to reach is the reset-status flag set while start is already 1. In that state a later start write must not clear the flag, because the clear needs a rising start. The stimulus reaches it by first starting the controller and then writing stop and start together. It then checks that neither a second start write nor a write of all ones to the status register clears bit 7. Same-cycle collisions are driven the same way: an event pulse is raised in the exact cycle of a status clear, and a transmit command is written while the previous transmit is still busy.

// File: rtl/nic_cmd_irq_pkg.sv
package nic_cmd_irq_pkg;

  localparam int unsigned DATA_W  = 8;
  localparam int unsigned EV_W    = 7;
  localparam int unsigned DMA_W   = 3;
  localparam int unsigned PAGE_W  = 2;

  localparam logic [DMA_W-1:0] DMA_ABORT = 3'd4;
  localparam logic [DMA_W-1:0] DMA_READ  = 3'd1;
  localparam logic [DMA_W-1:0] DMA_BAD   = 3'd0;

  localparam int unsigned EV_RX     = 0;
  localparam int unsigned EV_TX     = 1;
  localparam int unsigned EV_RXERR  = 2;
  localparam int unsigned EV_TXERR  = 3;
  localparam int unsigned EV_OVW    = 4;
  localparam int unsigned EV_CNT    = 5;
  localparam int unsigned EV_DMA    = 6;

  typedef enum logic [1:0] {
    RD_NONE = 2'd0,
    RD_CMD  = 2'd1,
    RD_STAT = 2'd2,
    RD_MASK = 2'd3
  } rdSel_t;

  typedef struct packed {
    logic              cmdWr;
    logic              statWr;
    logic              maskWr;
    logic [EV_W-1:0]   clrBits;
    logic [EV_W-1:0]   maskBits;
    logic [PAGE_W-1:0] newPage;
    logic [DMA_W-1:0]  newDma;
    logic              txReq;
    logic              startReq;
    logic              stopReq;
    logic              startRise;
    logic              zeroRead;
    rdSel_t            rdSel;
  } ctlStrobes_t;

endpackage

// File: rtl/nic_cmd_ctrl.sv
module nic_cmd_ctrl
  import nic_cmd_irq_pkg::*;
#(
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned CMD_OFS  = 0,
  parameter int unsigned STAT_OFS = 7,
  parameter int unsigned MASK_OFS = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  logic [PAGE_W-1:0] curPage,
  input  logic              startNow,
  input  logic              remCntZero,
  output ctlStrobes_t       stb
);

  localparam logic [ADDR_W-1:0] CMD_A  = ADDR_W'(CMD_OFS);
  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_OFS);
  localparam logic [ADDR_W-1:0] MASK_A = ADDR_W'(MASK_OFS);
  localparam logic [PAGE_W-1:0] PG0    = '0;
  localparam logic [PAGE_W-1:0] PG2    = PAGE_W'(2);

  logic              hitCmd;
  logic              hitStat;
  logic              hitMaskW;
  logic              hitMaskR;
  logic [DMA_W-1:0]  rawDma;

  always_comb begin
    hitCmd   = (regAddr == CMD_A);
    hitStat  = (regAddr == STAT_A) && (curPage == PG0);
    hitMaskW = (regAddr == MASK_A) && (curPage == PG0);
    hitMaskR = (regAddr == MASK_A) && (curPage == PG2);
    rawDma   = regWrData[5:3];
  end

  always_comb begin
    stb           = '0;
    stb.cmdWr     = regWr && hitCmd;
    stb.statWr    = regWr && hitStat;
    stb.maskWr    = regWr && hitMaskW;
    stb.clrBits   = stb.statWr ? regWrData[EV_W-1:0] : '0;
    stb.maskBits  = regWrData[EV_W-1:0];
    stb.newPage   = regWrData[7:6];
    stb.newDma    = (rawDma == DMA_BAD) ? DMA_ABORT : rawDma;
    stb.txReq     = regWrData[2];
    stb.startReq  = regWrData[1];
    stb.stopReq   = regWrData[0];
    stb.startRise = stb.cmdWr && regWrData[1] && !startNow;
    stb.zeroRead  = stb.cmdWr && (stb.newDma == DMA_READ) && regWrData[1] && remCntZero;
    if (hitCmd)        stb.rdSel = RD_CMD;
    else if (hitStat)  stb.rdSel = RD_STAT;
    else if (hitMaskR) stb.rdSel = RD_MASK;
    else               stb.rdSel = RD_NONE;
  end

  // only one register is written per access (R1, R6, R7)
  p_one_target_r6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.cmdWr, stb.statWr, stb.maskWr}));

  // the decoded DMA code is never the illegal value (R2)
  p_no_bad_code_r2: assert property (@(posedge clk) disable iff (!rstN)
    stb.cmdWr |-> (stb.newDma != DMA_BAD));

endmodule

// File: rtl/nic_cmd_dp.sv
module nic_cmd_dp
  import nic_cmd_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       stb,
  input  logic [EV_W-1:0]   evRaw,
  input  logic              txDoneEv,
  output logic [DATA_W-1:0] rdData,
  output logic              irq,
  output logic              txStart,
  output logic              txBusy,
  output logic              txOk,
  output logic [PAGE_W-1:0] pageQ,
  output logic [DMA_W-1:0]  dmaQ,
  output logic              startQ,
  output logic              stopQ
);

  logic              rstFlagQ;
  logic [EV_W-1:0]   statQ;
  logic [EV_W-1:0]   maskQ;
  logic [EV_W-1:0]   setVec;
  logic              txAccept;
  logic              txFinish;

  always_comb begin
    txAccept        = stb.cmdWr && stb.txReq && !txBusy;
    txFinish        = txDoneEv && txBusy;
    setVec          = evRaw;
    setVec[EV_TX]   = txFinish;
    setVec[EV_DMA]  = evRaw[EV_DMA] | stb.zeroRead;
  end

  // command fields
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pageQ  <= '0;
      dmaQ   <= DMA_ABORT;
      startQ <= 1'b0;
      stopQ  <= 1'b1;
    end else if (stb.cmdWr) begin
      pageQ  <= stb.newPage;
      dmaQ   <= stb.newDma;
      startQ <= stb.startReq;
      stopQ  <= stb.stopReq;
    end
  end

  // sticky reset-status flag
  always_ff @(posedge clk) begin
    if (!rstN)           rstFlagQ <= 1'b1;
    else if (stb.cmdWr)  rstFlagQ <= (rstFlagQ | stb.stopReq) & ~stb.startRise;
  end

  // one flop per status bit: an event beats a clear in the same cycle
  for (genvar gi = 0; gi < EV_W; gi++) begin : g_stat
    always_ff @(posedge clk) begin
      if (!rstN)            statQ[gi] <= 1'b0;
      else if (setVec[gi])  statQ[gi] <= 1'b1;
      else if (stb.clrBits[gi]) statQ[gi] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)           maskQ <= '0;
    else if (stb.maskWr) maskQ <= stb.maskBits;
  end

  // transmit handshake
  always_ff @(posedge clk) begin
    if (!rstN) begin
      txStart <= 1'b0;
      txBusy  <= 1'b0;
      txOk    <= 1'b0;
    end else begin
      txStart <= txAccept;
      if (txAccept) begin
        txBusy <= 1'b1;
        txOk   <= 1'b0;
      end else if (txFinish) begin
        txBusy <= 1'b0;
        txOk   <= 1'b1;
      end
    end
  end

  always_comb irq = |(statQ & maskQ);

  always_comb begin
    unique case (stb.rdSel)
      RD_CMD:  rdData = {pageQ, dmaQ, txBusy, startQ, stopQ};
      RD_STAT: rdData = {rstFlagQ, statQ};
      RD_MASK: rdData = {1'b0, maskQ};
      default: rdData = '0;
    endcase
  end

  // reset-status only falls after a start-rising command write (R4)
  p_rst_sticky_r4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rstFlagQ) |-> $past(stb.startRise));

  // a stop write without a start rise leaves reset-status set (R3)
  p_stop_sets_rst_r3: assert property (@(posedge clk) disable iff (!rstN)
    (stb.cmdWr && stb.stopReq && !stb.startRise) |=> rstFlagQ);

  // received-packet event is never lost to a simultaneous clear (R11)
  p_event_wins_r11: assert property (@(posedge clk) disable iff (!rstN)
    evRaw[EV_RX] |=> statQ[EV_RX]);

  // an accepted transmit command shows as busy next cycle (R10)
  p_tx_busy_r10: assert property (@(posedge clk) disable iff (!rstN)
    txStart |-> txBusy);

  // no second start pulse while a transmit is outstanding (R12)
  p_no_restart_r12: assert property (@(posedge clk) disable iff (!rstN)
    (txBusy && !txDoneEv) |=> !txStart);

  // stored DMA code is never the illegal value (R2)
  p_dma_legal_r2: assert property (@(posedge clk) disable iff (!rstN)
    dmaQ != DMA_BAD);

endmodule

// File: rtl/nic_cmd_irq.sv
module nic_cmd_irq
  import nic_cmd_irq_pkg::*;
#(
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned CMD_OFS  = 0,
  parameter int unsigned STAT_OFS = 7,
  parameter int unsigned MASK_OFS = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [7:0]        regWrData,
  output logic [7:0]        regRdData,
  input  logic              rxDoneEv,
  input  logic              rxErrEv,
  input  logic              txErrEv,
  input  logic              ovwEv,
  input  logic              cntOvfEv,
  input  logic              dmaDoneEv,
  input  logic              txDoneEv,
  input  logic              remCntZero,
  output logic              irq,
  output logic              txStart,
  output logic              txBusy,
  output logic              txOk,
  output logic [1:0]        pageSel,
  output logic [2:0]        dmaCmd,
  output logic              running,
  output logic              stopped
);

  ctlStrobes_t     stb;
  logic [EV_W-1:0] evRaw;

  always_comb begin
    evRaw           = '0;
    evRaw[EV_RX]    = rxDoneEv;
    evRaw[EV_RXERR] = rxErrEv;
    evRaw[EV_TXERR] = txErrEv;
    evRaw[EV_OVW]   = ovwEv;
    evRaw[EV_CNT]   = cntOvfEv;
    evRaw[EV_DMA]   = dmaDoneEv;
  end

  nic_cmd_ctrl #(
    .ADDR_W(ADDR_W), .CMD_OFS(CMD_OFS), .STAT_OFS(STAT_OFS), .MASK_OFS(MASK_OFS)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .regWr      (regWr),
    .regAddr    (regAddr),
    .regWrData  (regWrData),
    .curPage    (pageSel),
    .startNow   (running),
    .remCntZero (remCntZero),
    .stb        (stb)
  );

  nic_cmd_dp u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .evRaw    (evRaw),
    .txDoneEv (txDoneEv),
    .rdData   (regRdData),
    .irq      (irq),
    .txStart  (txStart),
    .txBusy   (txBusy),
    .txOk     (txOk),
    .pageQ    (pageSel),
    .dmaQ     (dmaCmd),
    .startQ   (running),
    .stopQ    (stopped)
  );

endmodule

// File: tb/nic_cmd_irq_bench.sv
`timescale 1ns/1ps
module nic_cmd_irq_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWr = 1'b0;
  logic [3:0] regAddr = '0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic rxDoneEv = 0, rxErrEv = 0, txErrEv = 0, ovwEv = 0;
  logic cntOvfEv = 0, dmaDoneEv = 0, txDoneEv = 0, remCntZero = 0;
  logic irq, txStart, txBusy, txOk, running, stopped;
  logic [1:0] pageSel;
  logic [2:0] dmaCmd;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  nic_cmd_irq u_nic_cmd_irq (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData),
    .rxDoneEv(rxDoneEv), .rxErrEv(rxErrEv), .txErrEv(txErrEv), .ovwEv(ovwEv),
    .cntOvfEv(cntOvfEv), .dmaDoneEv(dmaDoneEv), .txDoneEv(txDoneEv),
    .remCntZero(remCntZero), .irq(irq), .txStart(txStart), .txBusy(txBusy),
    .txOk(txOk), .pageSel(pageSel), .dmaCmd(dmaCmd), .running(running),
    .stopped(stopped)
  );

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    regWr = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic rdChk(string req, input logic [3:0] a, input logic [7:0] exp);
    @(negedge clk);
    regAddr = a;
    #1;
    chk(req, $sformatf("read @%0d", a), regRdData, exp);
  endtask

  task automatic pulse(ref logic sig);
    @(negedge clk);
    sig = 1'b1;
    @(negedge clk);
    sig = 1'b0;
  endtask

  task automatic t_reset();
    chk("R8", "stopped", stopped, 1);
    chk("R8", "running", running, 0);
    chk("R8", "dmaCmd", dmaCmd, 4);
    chk("R8", "pageSel", pageSel, 0);
    chk("R8", "irq", irq, 0);
    chk("R8", "txBusy", txBusy, 0);
    chk("R8", "txOk", txOk, 0);
    rdChk("R8", 4'd0, 8'h21);
    rdChk("R8", 4'd7, 8'h80);
  endtask

  task automatic t_command();
    wr(4'd0, 8'h02);
    rdChk("R2", 4'd0, 8'h22);
    chk("R2", "dmaCmd", dmaCmd, 4);
    rdChk("R4", 4'd7, 8'h00);
    chk("R3", "stopped", stopped, 0);
    chk("R1", "running", running, 1);
    wr(4'd0, 8'h53);
    chk("R1", "pageSel", pageSel, 1);
    chk("R1", "dmaCmd", dmaCmd, 2);
    rdChk("R1", 4'd0, 8'h53);
  endtask

  task automatic t_sticky();
    wr(4'd0, 8'h23);
    rdChk("R3", 4'd7, 8'h80);
    chk("R3", "stopped", stopped, 1);
    wr(4'd0, 8'h22);
    rdChk("R4", 4'd7, 8'h80);
    wr(4'd7, 8'hFF);
    rdChk("R4", 4'd7, 8'h80);
    wr(4'd0, 8'h21);
    wr(4'd0, 8'h22);
    rdChk("R4", 4'd7, 8'h00);
    wr(4'd0, 8'h21);
    rdChk("R3", 4'd7, 8'h80);
    wr(4'd0, 8'h23);
    rdChk("R4", 4'd7, 8'h00);
    wr(4'd0, 8'h22);
    rdChk("R3", 4'd0, 8'h22);
  endtask

  task automatic t_events();
    pulse(rxDoneEv);
    rdChk("R5", 4'd7, 8'h01);
    pulse(rxErrEv);
    pulse(txErrEv);
    pulse(ovwEv);
    pulse(cntOvfEv);
    pulse(dmaDoneEv);
    rdChk("R5", 4'd7, 8'h7D);
    chk("R7", "irq unmasked off", irq, 0);
    wr(4'd15, 8'h20);
    chk("R7", "irq on mask", irq, 1);
    wr(4'd7, 8'h01);
    rdChk("R6", 4'd7, 8'h7C);
    chk("R7", "irq held", irq, 1);
    wr(4'd7, 8'h20);
    rdChk("R6", 4'd7, 8'h5C);
    chk("R7", "irq drop clear", irq, 0);
    wr(4'd15, 8'h04);
    chk("R7", "irq on mask2", irq, 1);
    wr(4'd15, 8'h00);
    chk("R7", "irq drop mask", irq, 0);
    wr(4'd7, 8'h7F);
    rdChk("R6", 4'd7, 8'h00);
  endtask

  task automatic t_pages();
    wr(4'd15, 8'hD5);
    wr(4'd0, 8'hA2);
    chk("R1", "pageSel", pageSel, 2);
    rdChk("R13", 4'd15, 8'h55);
    wr(4'd15, 8'hFF);
    rdChk("R13", 4'd15, 8'h55);
    rdChk("R13", 4'd3, 8'h00);
    pulse(rxDoneEv);
    rdChk("R13", 4'd7, 8'h00);
    wr(4'd7, 8'h01);
    wr(4'd0, 8'h22);
    rdChk("R6", 4'd7, 8'h01);
    rdChk("R13", 4'd15, 8'h00);
    wr(4'd7, 8'h01);
    wr(4'd15, 8'h00);
  endtask

  task automatic t_priority();
    pulse(rxErrEv);
    @(negedge clk);
    rxErrEv = 1'b1; regWr = 1'b1; regAddr = 4'd7; regWrData = 8'h04;
    @(negedge clk);
    rxErrEv = 1'b0; regWr = 1'b0;
    rdChk("R11", 4'd7, 8'h04);
    wr(4'd7, 8'h04);
    rdChk("R11", 4'd7, 8'h00);
  endtask

  task automatic t_zero_read();
    wr(4'd15, 8'h40);
    remCntZero = 1'b1;
    wr(4'd0, 8'h0A);
    chk("R9", "dmaCmd", dmaCmd, 1);
    rdChk("R9", 4'd7, 8'h40);
    chk("R9", "irq", irq, 1);
    wr(4'd7, 8'h40);
    remCntZero = 1'b0;
    wr(4'd0, 8'h0A);
    rdChk("R9", 4'd7, 8'h00);
    remCntZero = 1'b1;
    wr(4'd0, 8'h08);
    rdChk("R9", 4'd7, 8'h00);
    remCntZero = 1'b0;
    wr(4'd15, 8'h00);
    wr(4'd0, 8'h22);
  endtask

  task automatic t_transmit();
    @(negedge clk);
    regWr = 1'b1; regAddr = 4'd0; regWrData = 8'h26;
    @(posedge clk); #1;
    chk("R10", "txStart pulse", txStart, 1);
    chk("R10", "txBusy", txBusy, 1);
    @(negedge clk);
    regWr = 1'b0;
    @(posedge clk); #1;
    chk("R10", "txStart width", txStart, 0);
    rdChk("R10", 4'd0, 8'h26);
    @(negedge clk);
    regWr = 1'b1; regWrData = 8'h26;
    @(posedge clk); #1;
    chk("R12", "no restart", txStart, 0);
    @(negedge clk);
    regWr = 1'b0;
    pulse(txDoneEv);
    chk("R10", "txBusy clear", txBusy, 0);
    chk("R10", "txOk", txOk, 1);
    rdChk("R10", 4'd7, 8'h02);
    rdChk("R10", 4'd0, 8'h22);
    wr(4'd7, 8'h02);
    pulse(txDoneEv);
    rdChk("R12", 4'd7, 8'h00);
    chk("R12", "txOk kept", txOk, 1);
    wr(4'd0, 8'h26);
    chk("R10", "txOk cleared", txOk, 0);
    pulse(txDoneEv);
    wr(4'd7, 8'h02);
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #100000;
    failures++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_command();
    t_sticky();
    t_events();
    t_pages();
    t_priority();
    t_zero_read();
    t_transmit();
    repeat (3) @(negedge clk);
    finishRun();
  end

endmodule